// File: doc/BRIEF.md
# BCD-Capable 8-bit ALU

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. On each cycle with `in_valid` high it takes an operation code, the accumulator byte, a second operand byte and the current carry and auxiliary-carry flags. One clock later it presents the new accumulator, the returned operand byte and the two new flags. Operand fetch and write-back are done by the surrounding datapath.

The operation set covers binary add with and without carry-in, the bitwise operations, increment, decrement, clear and complement, decimal adjust, the four rotates, nibble swap and a low-nibble exchange between accumulator and operand. Decimal adjust is meant to follow an add of two packed-BCD bytes, with the flags from that add fed back in. It then turns the binary sum into a valid two-digit BCD result. Its carry output can be set but never cleared, so a decimal carry out of the add survives the adjust.

Top module: `bcd_alu`

## Requirements
- R1: While `rst_n` is low, `acc_out`, `opnd_out`, `cy_out`, `ac_out` and `out_valid` are all 0.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. In a cycle after `in_valid` was low, all data outputs hold their values.
- R3: Op 0 (add) returns acc+opnd and ignores `cy_in`. Op 1 (add with carry) returns acc+opnd+`cy_in`. For both, `cy_out` is the carry out of bit 7.
- R4: For ops 0 and 1, `ac_out` is 1 exactly when the sum of the two low nibbles plus the carry-in used exceeds 0xF.
- R5: Op 2 gives AND, op 3 OR, op 4 XOR, op 5 acc+1, op 6 acc-1 and op 7 zero (all modulo 256). Op 8 gives the complement of acc. All of them return `cy_in` and `ac_in` unchanged.
- R6: Op 9 (decimal adjust) first adds 6 when `ac_in` is 1 or acc[3:0] > 9. It then adds 0x60 when `cy_in` is 1, when the first step carried out of bit 7, or when the intermediate byte exceeds 0x99.
- R7: For op 9, `cy_out` is `cy_in` ORed with any carry out of either adjust step, so a set carry is never cleared. `ac_out` equals `ac_in`.
- R8: Op 11 rotates left through carry: bit 7 goes to `cy_out` and `cy_in` goes to bit 0. Op 13 rotates right through carry: bit 0 goes to `cy_out` and `cy_in` goes to bit 7.
- R9: Op 10 rotates acc left (bit 7 into bit 0) and op 12 rotates it right (bit 0 into bit 7). Both leave the carry unchanged.
- R10: Op 14 swaps acc[7:4] with acc[3:0]. Op 15 exchanges acc[3:0] with opnd[3:0] and keeps both upper nibbles. Every op other than 15 returns `opnd_out` equal to `opnd_in`.
- R11: For every pair of decimal values 0..99 in packed BCD, an op 0 followed by an op 9 (fed the first result and flags) gives the BCD of the sum modulo 100, with `cy_out` = 1 exactly when the sum is 100 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see R3 to R10) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand byte |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| out_valid | output | 1 | Result present |
| acc_out | output | 8 | New accumulator |
| opnd_out | output | 8 | Returned operand byte |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary carry flag |

## Verification
Every result, flags included, is due exactly one rising edge after its operation was accepted. There is no operation-dependent delay, so the decimal adjust is no slower than a clear. The driver applies one operation per falling edge and queues its expected result. The monitor compares the head of that queue on the next falling edge where `out_valid` is high, so each result is sampled half a cycle after the edge that produced it. A decimal add and its adjust are issued back to back, and the adjust takes the bench's own expected add result as input rather than the design's output.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_INC  = 4'd5,
        OP_DEC  = 4'd6,
        OP_CLR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_DADJ = 4'd9,
        OP_ROL  = 4'd10,
        OP_ROLC = 4'd11,
        OP_ROR  = 4'd12,
        OP_RORC = 4'd13,
        OP_SWAP = 4'd14,
        OP_XLO  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] opnd;
        logic              cy;
        logic              ac;
    } alu_res_t;

    typedef struct packed {
        alu_res_t res;
        logic     vld;
    } alu_state_t;

endpackage

// File: rtl/bcd_alu_arith.sv
module bcd_alu_arith
    import bcd_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    input  logic              cy,
    input  logic              ac,
    output alu_res_t          res
);
    localparam logic [DATA_W:0] LO_ADJ  = (DATA_W+1)'(6);
    localparam logic [DATA_W:0] HI_ADJ  = (DATA_W+1)'(8'h60);
    localparam logic [DATA_W-1:0] HI_LIM = DATA_W'(8'h99);
    localparam logic [NIB_W-1:0]  LO_LIM = NIB_W'(9);

    logic              cin;
    logic [DATA_W:0]   sum_full;
    logic [NIB_W:0]    half_sum;
    logic [DATA_W:0]   step1;
    logic              step1_cy;
    logic [DATA_W:0]   step2;

    always_comb begin
        cin      = (op == OP_ADDC) ? cy : 1'b0;
        sum_full = {1'b0, acc} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin};
        half_sum = {1'b0, acc[NIB_W-1:0]} + {1'b0, opnd[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin};

        step1    = {1'b0, acc}
                 + ((ac || (acc[NIB_W-1:0] > LO_LIM)) ? LO_ADJ : '0);
        step1_cy = step1[DATA_W];
        step2    = {1'b0, step1[DATA_W-1:0]}
                 + ((cy || step1_cy || (step1[DATA_W-1:0] > HI_LIM)) ? HI_ADJ : '0);

        res.acc  = acc;
        res.opnd = opnd;
        res.cy   = cy;
        res.ac   = ac;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                res.acc = sum_full[DATA_W-1:0];
                res.cy  = sum_full[DATA_W];
                res.ac  = half_sum[NIB_W];
            end
            OP_INC:  res.acc = acc + 1'b1;
            OP_DEC:  res.acc = acc - 1'b1;
            OP_DADJ: begin
                res.acc = step2[DATA_W-1:0];
                res.cy  = cy | step1_cy | step2[DATA_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bcd_alu_logic.sv
module bcd_alu_logic
    import bcd_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    input  logic              cy,
    input  logic              ac,
    output alu_res_t          res
);
    always_comb begin
        res.acc  = acc;
        res.opnd = opnd;
        res.cy   = cy;
        res.ac   = ac;
        unique case (op)
            OP_AND:  res.acc = acc & opnd;
            OP_OR:   res.acc = acc | opnd;
            OP_XOR:  res.acc = acc ^ opnd;
            OP_CLR:  res.acc = '0;
            OP_CPL:  res.acc = ~acc;
            default: ;
        endcase
    end
endmodule

// File: rtl/bcd_alu_shift.sv
module bcd_alu_shift
    import bcd_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    input  logic              cy,
    input  logic              ac,
    output alu_res_t          res
);
    always_comb begin
        res.acc  = acc;
        res.opnd = opnd;
        res.cy   = cy;
        res.ac   = ac;
        unique case (op)
            OP_ROL:  res.acc = {acc[DATA_W-2:0], acc[DATA_W-1]};
            OP_ROR:  res.acc = {acc[0], acc[DATA_W-1:1]};
            OP_ROLC: begin
                res.acc = {acc[DATA_W-2:0], cy};
                res.cy  = acc[DATA_W-1];
            end
            OP_RORC: begin
                res.acc = {cy, acc[DATA_W-1:1]};
                res.cy  = acc[0];
            end
            OP_SWAP: res.acc = {acc[NIB_W-1:0], acc[DATA_W-1:NIB_W]};
            OP_XLO: begin
                res.acc  = {acc[DATA_W-1:NIB_W], opnd[NIB_W-1:0]};
                res.opnd = {opnd[DATA_W-1:NIB_W], acc[NIB_W-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
    import bcd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              cy_in,
    input  logic              ac_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] opnd_out,
    output logic              cy_out,
    output logic              ac_out
);
    alu_op_e    op_e;
    alu_res_t   arith_res, logic_res, shift_res, pick_res;
    alu_state_t st_d, st_q;

    assign op_e = alu_op_e'(op);

    bcd_alu_arith u_arith (
        .op(op_e), .acc(acc_in), .opnd(opnd_in), .cy(cy_in), .ac(ac_in),
        .res(arith_res)
    );
    bcd_alu_logic u_logic (
        .op(op_e), .acc(acc_in), .opnd(opnd_in), .cy(cy_in), .ac(ac_in),
        .res(logic_res)
    );
    bcd_alu_shift u_shift (
        .op(op_e), .acc(acc_in), .opnd(opnd_in), .cy(cy_in), .ac(ac_in),
        .res(shift_res)
    );

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_ADDC, OP_INC, OP_DEC, OP_DADJ:
                pick_res = arith_res;
            OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL:
                pick_res = logic_res;
            default:
                pick_res = shift_res;
        endcase
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.res = pick_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign acc_out   = st_q.res.acc;
    assign opnd_out  = st_q.res.opnd;
    assign cy_out    = st_q.res.cy;
    assign ac_out    = st_q.res.ac;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_out) && $stable(cy_out) && $stable(opnd_out));

    a_r7_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_DADJ && cy_in) |=> cy_out);

    a_r7_adjust_keeps_ac: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_DADJ) |=> ac_out == $past(ac_in));

    a_r5_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= OP_AND && op <= OP_CPL)
        |=> (cy_out == $past(cy_in)) && (ac_out == $past(ac_in)));

    a_r9_rotate_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_ROL || op == OP_ROR)) |=> cy_out == $past(cy_in));

    a_r10_low_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_XLO)
        |=> (acc_out[NIB_W-1:0] == $past(opnd_in[NIB_W-1:0]))
         && (opnd_out[NIB_W-1:0] == $past(acc_in[NIB_W-1:0])));

    a_r10_opnd_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_XLO) |=> opnd_out == $past(opnd_in));
endmodule

// File: tb/tb_bcd_alu.sv
`timescale 1ns/1ps
module tb_bcd_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] acc_in = '0, opnd_in = '0;
    logic       cy_in = 1'b0, ac_in = 1'b0;
    logic       out_valid;
    logic [7:0] acc_out, opnd_out;
    logic       cy_out, ac_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] acc;
        logic [7:0] opnd;
        logic       cy;
        logic       ac;
        string      req;
    } exp_t;
    exp_t scb[$];

    always #2.5 clk = ~clk;

    bcd_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in),
        .out_valid(out_valid), .acc_out(acc_out), .opnd_out(opnd_out),
        .cy_out(cy_out), .ac_out(ac_out)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    task automatic send(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic c, input logic h,
                        input logic [7:0] ea, input logic [7:0] eb,
                        input logic ec, input logic eh, input string req);
        exp_t e;
        e.acc = ea; e.opnd = eb; e.cy = ec; e.ac = eh; e.req = req;
        scb.push_back(e);
        op = o; acc_in = a; opnd_in = b; cy_in = c; ac_in = h; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // add or add-with-carry with expectation from plain integer sums
    task automatic send_add(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                            input logic c, input logic h, input string req);
        int ci, s, hs;
        ci = (o == 4'd1) ? int'(c) : 0;
        s  = int'(a) + int'(b) + ci;
        hs = int'(a % 16) + int'(b % 16) + ci;
        send(o, a, b, c, h, 8'(s % 256), b, s > 255, hs > 15, req);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            n_checks++;
            if (scb.size() == 0) begin
                n_fails++;
                $display("FAIL R2: result with no pending operation, actual acc=%h expected none",
                         acc_out);
            end else begin
                exp_t e;
                e = scb.pop_front();
                if (acc_out !== e.acc || opnd_out !== e.opnd ||
                    cy_out !== e.cy || ac_out !== e.ac) begin
                    n_fails++;
                    $display("FAIL %s: actual acc=%h opnd=%h cy=%b ac=%b expected acc=%h opnd=%h cy=%b ac=%b",
                             e.req, acc_out, opnd_out, cy_out, ac_out,
                             e.acc, e.opnd, e.cy, e.ac);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (out_valid !== 1'b0 || acc_out !== 8'h00 || opnd_out !== 8'h00 ||
            cy_out !== 1'b0 || ac_out !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: actual v=%b acc=%h opnd=%h cy=%b ac=%b expected all zero",
                     out_valid, acc_out, opnd_out, cy_out, ac_out);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4: binary adds
        send_add(4'd0, 8'h0F, 8'h01, 1'b1, 1'b0, "R3_R4 add ignores carry-in");
        send_add(4'd1, 8'hFF, 8'h00, 1'b1, 1'b0, "R3_R4 addc wrap");
        send_add(4'd0, 8'h80, 8'h80, 1'b0, 1'b1, "R3 add carry out");
        send_add(4'd1, 8'h07, 8'h08, 1'b1, 1'b0, "R4 half carry from carry-in");

        // R5: logic, inc, dec, clear, complement keep flags
        send(4'd2, 8'hF0, 8'h3C, 1'b1, 1'b0, 8'h30, 8'h3C, 1'b1, 1'b0, "R5 and");
        send(4'd3, 8'hF0, 8'h3C, 1'b0, 1'b1, 8'hFC, 8'h3C, 1'b0, 1'b1, "R5 or");
        send(4'd4, 8'hF0, 8'h3C, 1'b1, 1'b1, 8'hCC, 8'h3C, 1'b1, 1'b1, "R5 xor");
        send(4'd5, 8'hFF, 8'h11, 1'b0, 1'b0, 8'h00, 8'h11, 1'b0, 1'b0, "R5 inc wrap");
        send(4'd6, 8'h00, 8'h22, 1'b1, 1'b0, 8'hFF, 8'h22, 1'b1, 1'b0, "R5 dec wrap");
        send(4'd7, 8'hA7, 8'h33, 1'b0, 1'b1, 8'h00, 8'h33, 1'b0, 1'b1, "R5 clear");
        send(4'd8, 8'h5A, 8'h44, 1'b1, 1'b1, 8'hA5, 8'h44, 1'b1, 1'b1, "R5 complement");

        // R6 / R7: decimal adjust corners
        send(4'd9, 8'h12, 8'h00, 1'b1, 1'b0, 8'h72, 8'h00, 1'b1, 1'b0, "R7 sticky carry adds 0x60");
        send(4'd9, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, "R6 both steps");
        send(4'd9, 8'h21, 8'h00, 1'b0, 1'b1, 8'h27, 8'h00, 1'b0, 1'b1, "R6 aux carry forces +6");
        send(4'd9, 8'hFA, 8'h00, 1'b0, 1'b0, 8'h60, 8'h00, 1'b1, 1'b0, "R7 first step carry kept");
        send(4'd9, 8'h45, 8'h00, 1'b0, 1'b0, 8'h45, 8'h00, 1'b0, 1'b0, "R6 no adjust");

        // R8 / R9: rotates
        send(4'd11, 8'h81, 8'h00, 1'b0, 1'b0, 8'h02, 8'h00, 1'b1, 1'b0, "R8 rotate left via carry");
        send(4'd13, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 8'h00, 1'b1, 1'b0, "R8 rotate right via carry");
        send(4'd13, 8'h02, 8'h00, 1'b0, 1'b1, 8'h01, 8'h00, 1'b0, 1'b1, "R8 rotate right clears carry");
        send(4'd10, 8'h81, 8'h00, 1'b0, 1'b0, 8'h03, 8'h00, 1'b0, 1'b0, "R9 rotate left");
        send(4'd12, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 8'h00, 1'b1, 1'b0, "R9 rotate right");

        // R10: swap and low-nibble exchange
        send(4'd14, 8'h3C, 8'h55, 1'b0, 1'b0, 8'hC3, 8'h55, 1'b0, 1'b0, "R10 swap");
        send(4'd15, 8'h12, 8'h34, 1'b1, 1'b1, 8'h14, 8'h32, 1'b1, 1'b1, "R10 low exchange");

        // R2: idle cycles produce no result
        repeat (2) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || scb.size() != 0 || acc_out !== 8'h14) begin
            n_fails++;
            $display("FAIL R2: actual v=%b pending=%0d acc=%h expected v=0 pending=0 acc=14",
                     out_valid, scb.size(), acc_out);
        end

        // R11: decimal sweep, add then adjust
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                int s, hs;
                logic [7:0] pa, pb;
                pa = to_bcd(a);
                pb = to_bcd(b);
                s  = int'(pa) + int'(pb);
                hs = int'(pa % 16) + int'(pb % 16);
                send(4'd0, pa, pb, 1'b0, 1'b0, 8'(s % 256), pb, s > 255, hs > 15, "R11 bcd add");
                send(4'd9, 8'(s % 256), 8'h00, s > 255, hs > 15,
                     to_bcd((a + b) % 100), 8'h00, (a + b) >= 100, hs > 15, "R11 bcd adjust");
            end
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule